// File: doc/BRIEF.md
# Dual-Bank Colour Gain Selector

This block keeps the gain settings for a three-colour optical power monitor and presents the one setting that is currently in use. For each colour (blue, red, green) it holds two 12-bit fine-gain codes: one for the high-gain bank and one for the low-gain bank. It also holds one 2-bit transimpedance gain code per bank, one slow-tail compensation setting per colour, a control register, a writable device-select byte and three fixed identification bytes. Every clock cycle it selects the fine-gain code, the transimpedance code and the slow-tail fields that apply to the active bank and colour.

Software uses a plain register bus. The bus has a write strobe, a shared 7-bit address, a write byte and a combinational read byte. The bus has no back-pressure, so a write is accepted on every clock edge that sees the strobe. The bank can be switched quickly from the `bank_pin` input, and a register bit can also force the low bank. The control register picks the colour. A write changes the selected outputs right after the clock edge that takes it, with no added latency. The analog chain and the DAC conversion that follows these codes are not part of this block.

Top module: `gain_bank_select`

## Requirements
- R1: After reset the control register reads 0x00, the transimpedance and slow-tail registers read 0x00, the device-select byte at 0x03 reads 0x43, every upper gain byte reads 0x7F and every shared nibble register reads 0xFF, so every fine-gain code starts at 0x7FF.
- R2: A fine-gain code is {upper byte, nibble}. The nibble comes from the colour's shared register: bits [7:4] for the high bank and bits [3:0] for the low bank. Blue uses shared/high/low bytes at 0x11/0x12/0x13, red uses 0x14/0x15/0x16 and green uses 0x17/0x18/0x19.
- R3: The high bank is active (`bank_high`=1) only when `bank_pin` is 1 and control bit 7 is 1. In every other case the low bank is active.
- R4: Control bit 5 set to 1 selects blue whatever the value of bit 4. With bit 5 at 0, bit 4 selects red (1) or green (0). `color_mode` is encoded as 0 green, 1 red, 2 blue.
- R5: Register 0x1C holds the high-bank transimpedance code in bits [3:2] and the low-bank code in bits [1:0]. Bits [7:4] read 0. `tia_code` follows the active bank.
- R6: The slow-tail registers are red 0x1A, green 0x1B and blue 0x1E. Each has an enable in bit 7, a time constant in [6:4] and a magnitude in [2:0], and bit 3 reads 0. A write with bit 7 at 0 stores 0x00. The outputs show the active colour's register.
- R7: Control bit 0 is the chip enable. While it is 0, `sleep` is 1 and `fine_gain`, `tia_code`, `tail_en`, `tail_time` and `tail_mag` are all 0.
- R8: Addresses 0x00, 0x01 and 0x02 always read 0x28, 0xE0 and 0x00, and writes to them are ignored. Address 0x03 is read/write.
- R9: Addresses with no register (0x04..0x0F, 0x1D, 0x1F and above) read 0x00, and writes to them change nothing.
- R10: A write changes the selected outputs and the read data in the cycle right after its clock edge. Control bits 6 and 3 are stored and read back, and control bits 2:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 7 | Register address for read and write |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte for `reg_addr`, combinational |
| bank_pin | input | 1 | Hardware bank select, 1 permits the high bank |
| sleep | output | 1 | Chip enable is off |
| bank_high | output | 1 | High bank is active |
| color_mode | output | 2 | Active colour: 0 green, 1 red, 2 blue |
| fine_gain | output | 12 | Active fine-gain code |
| tia_code | output | 2 | Active transimpedance code |
| tail_en | output | 1 | Active slow-tail enable |
| tail_time | output | 3 | Active slow-tail time constant |
| tail_mag | output | 3 | Active slow-tail magnitude |

## Verification
Two events can fall in the same cycle: `bank_pin` toggles at the same edge where a register write changes either the code of the bank being left or the control bits that pick the colour. The random phase drives pin changes and writes on the same negative edges, so both arrive at one rising edge. A behavioural model applies the write and re-derives the selection from the new pin value. All outputs and the read byte are then compared with the model after every edge, so a stale bank, a one-cycle lag or a misplaced nibble shows up as a mismatch.

// File: rtl/rgbsel_pkg.sv
package rgbsel_pkg;
  typedef enum logic [1:0] {
    COL_GREEN = 2'd0,
    COL_RED   = 2'd1,
    COL_BLUE  = 2'd2
  } color_e;

  // colour slot order inside the bank array: 0 blue, 1 red, 2 green
  localparam int NCOL      = 3;
  localparam int SLOT_BLUE = 0;
  localparam int SLOT_RED  = 1;
  localparam int SLOT_GRN  = 2;

  localparam int ADR_ID0  = 'h00;
  localparam int ADR_ID1  = 'h01;
  localparam int ADR_ID2  = 'h02;
  localparam int ADR_DSEL = 'h03;
  localparam int ADR_CTRL = 'h10;
  localparam int ADR_TIA  = 'h1C;
  localparam int ADR_GAIN0 = 'h11;  // first colour's shared nibble register

  localparam logic [7:0] ID0_VAL   = 8'h28;
  localparam logic [7:0] ID1_VAL   = 8'hE0;
  localparam logic [7:0] ID2_VAL   = 8'h00;
  localparam logic [7:0] DSEL_RST  = 8'h43;
  localparam logic [7:0] CTRL_MASK = 8'hF9;
  localparam logic [7:0] TIA_MASK  = 8'h0F;
  localparam logic [7:0] TAIL_MASK = 8'hF7;

  localparam int CTL_BANK = 7;
  localparam int CTL_BLUE = 5;
  localparam int CTL_RED  = 4;
  localparam int CTL_EN   = 0;
  localparam int TAIL_EN  = 7;

  function automatic int gain_base(input int slot);
    return ADR_GAIN0 + 3 * slot;
  endfunction

  function automatic int tail_addr(input int slot);
    case (slot)
      SLOT_BLUE: return 'h1E;
      SLOT_RED:  return 'h1A;
      default:   return 'h1B;
    endcase
  endfunction
endpackage

// File: rtl/rgbsel_color_bank.sv
module rgbsel_color_bank #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int GAIN_W   = 12,
  parameter int BASE_ADR = 'h11,
  parameter int TAIL_ADR = 'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [GAIN_W-1:0] code_hi,
  output logic [GAIN_W-1:0] code_lo,
  output logic [DATA_W-1:0] tail_q,
  output logic [DATA_W-1:0] rd_data
);
  import rgbsel_pkg::*;

  localparam int NIB_W = GAIN_W - DATA_W;
  localparam logic [GAIN_W-1:0] GAIN_RST = {1'b0, {(GAIN_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] BYTE_RST = GAIN_RST[GAIN_W-1:NIB_W];
  localparam logic [NIB_W-1:0]  NIB_RST  = GAIN_RST[NIB_W-1:0];

  logic [DATA_W-1:0] nib_q, hi_q, lo_q;
  logic hit_nib, hit_hi, hit_lo, hit_tail;

  assign hit_nib  = (addr == ADDR_W'(BASE_ADR));
  assign hit_hi   = (addr == ADDR_W'(BASE_ADR + 1));
  assign hit_lo   = (addr == ADDR_W'(BASE_ADR + 2));
  assign hit_tail = (addr == ADDR_W'(TAIL_ADR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nib_q  <= {NIB_RST, NIB_RST};
      hi_q   <= BYTE_RST;
      lo_q   <= BYTE_RST;
      tail_q <= '0;
    end else if (wr_en) begin
      if (hit_nib) nib_q <= wdata;
      if (hit_hi)  hi_q  <= wdata;
      if (hit_lo)  lo_q  <= wdata;
      if (hit_tail) begin
        // a cleared enable also clears time and magnitude
        if (wdata[TAIL_EN]) tail_q <= wdata & DATA_W'(TAIL_MASK);
        else                tail_q <= '0;
      end
    end
  end

  assign code_hi = {hi_q, nib_q[2*NIB_W-1:NIB_W]};
  assign code_lo = {lo_q, nib_q[NIB_W-1:0]};

  always_comb begin
    rd_data = '0;
    if (hit_nib)       rd_data = nib_q;
    else if (hit_hi)   rd_data = hi_q;
    else if (hit_lo)   rd_data = lo_q;
    else if (hit_tail) rd_data = tail_q;
  end
endmodule

// File: rtl/rgbsel_ctrl_regs.sv
module rgbsel_ctrl_regs #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] tia_q,
  output logic [DATA_W-1:0] rd_data
);
  import rgbsel_pkg::*;

  logic [DATA_W-1:0] dsel_q;
  logic hit_ctrl, hit_tia, hit_dsel;

  assign hit_ctrl = (addr == ADDR_W'(ADR_CTRL));
  assign hit_tia  = (addr == ADDR_W'(ADR_TIA));
  assign hit_dsel = (addr == ADDR_W'(ADR_DSEL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tia_q  <= '0;
      dsel_q <= DATA_W'(DSEL_RST);
    end else if (wr_en) begin
      if (hit_ctrl) ctrl_q <= wdata & DATA_W'(CTRL_MASK);
      if (hit_tia)  tia_q  <= wdata & DATA_W'(TIA_MASK);
      if (hit_dsel) dsel_q <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit_ctrl)                          rd_data = ctrl_q;
    else if (hit_tia)                      rd_data = tia_q;
    else if (hit_dsel)                     rd_data = dsel_q;
    else if (addr == ADDR_W'(ADR_ID0))     rd_data = DATA_W'(ID0_VAL);
    else if (addr == ADDR_W'(ADR_ID1))     rd_data = DATA_W'(ID1_VAL);
    else if (addr == ADDR_W'(ADR_ID2))     rd_data = DATA_W'(ID2_VAL);
  end
endmodule

// File: rtl/rgbsel_select.sv
module rgbsel_select #(
  parameter int DATA_W = 8,
  parameter int GAIN_W = 12,
  parameter int NCOL   = 3
) (
  input  logic                         bank_pin,
  input  logic [DATA_W-1:0]            ctrl_q,
  input  logic [DATA_W-1:0]            tia_q,
  input  logic [NCOL-1:0][GAIN_W-1:0]  code_hi,
  input  logic [NCOL-1:0][GAIN_W-1:0]  code_lo,
  input  logic [NCOL-1:0][DATA_W-1:0]  tail_q,
  output logic                         sleep,
  output logic                         bank_high,
  output logic [1:0]                   color_mode,
  output logic [GAIN_W-1:0]            fine_gain,
  output logic [1:0]                   tia_code,
  output logic                         tail_en,
  output logic [2:0]                   tail_time,
  output logic [2:0]                   tail_mag
);
  import rgbsel_pkg::*;

  color_e col;
  int unsigned slot;
  logic [DATA_W-1:0] tail_sel;
  logic [GAIN_W-1:0] code_sel;
  logic [1:0] tia_sel;

  always_comb begin
    if (ctrl_q[CTL_BLUE])     begin col = COL_BLUE;  slot = SLOT_BLUE; end
    else if (ctrl_q[CTL_RED]) begin col = COL_RED;   slot = SLOT_RED;  end
    else                      begin col = COL_GREEN; slot = SLOT_GRN;  end
  end

  assign bank_high  = bank_pin & ctrl_q[CTL_BANK];
  assign color_mode = col;
  assign sleep      = ~ctrl_q[CTL_EN];

  assign code_sel = bank_high ? code_hi[slot] : code_lo[slot];
  assign tia_sel  = bank_high ? tia_q[3:2] : tia_q[1:0];
  assign tail_sel = tail_q[slot];

  always_comb begin
    if (sleep) begin
      fine_gain = '0;
      tia_code  = '0;
      tail_en   = 1'b0;
      tail_time = '0;
      tail_mag  = '0;
    end else begin
      fine_gain = code_sel;
      tia_code  = tia_sel;
      tail_en   = tail_sel[TAIL_EN];
      tail_time = tail_sel[6:4];
      tail_mag  = tail_sel[2:0];
    end
  end
endmodule

// File: rtl/gain_bank_select.sv
module gain_bank_select #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int GAIN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bank_pin,
  output logic              sleep,
  output logic              bank_high,
  output logic [1:0]        color_mode,
  output logic [GAIN_W-1:0] fine_gain,
  output logic [1:0]        tia_code,
  output logic              tail_en,
  output logic [2:0]        tail_time,
  output logic [2:0]        tail_mag
);
  import rgbsel_pkg::*;

  logic [NCOL-1:0][GAIN_W-1:0] code_hi, code_lo;
  logic [NCOL-1:0][DATA_W-1:0] tail_q, bank_rd;
  logic [DATA_W-1:0] ctrl_q, tia_q, ctl_rd;

  rgbsel_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .tia_q(tia_q), .rd_data(ctl_rd)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    rgbsel_color_bank #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W),
      .BASE_ADR(gain_base(c)), .TAIL_ADR(tail_addr(c))
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .code_hi(code_hi[c]), .code_lo(code_lo[c]), .tail_q(tail_q[c]),
      .rd_data(bank_rd[c])
    );
  end

  always_comb begin
    reg_rdata = ctl_rd;
    for (int c = 0; c < NCOL; c++) reg_rdata = reg_rdata | bank_rd[c];
  end

  rgbsel_select #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .NCOL(NCOL)) u_sel (
    .bank_pin(bank_pin), .ctrl_q(ctrl_q), .tia_q(tia_q),
    .code_hi(code_hi), .code_lo(code_lo), .tail_q(tail_q),
    .sleep(sleep), .bank_high(bank_high), .color_mode(color_mode),
    .fine_gain(fine_gain), .tia_code(tia_code), .tail_en(tail_en),
    .tail_time(tail_time), .tail_mag(tail_mag)
  );
endmodule

// File: rtl/gain_bank_select_checker.sv
module gain_bank_select_checker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int GAIN_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              bank_pin,
  input logic              sleep,
  input logic              bank_high,
  input logic [1:0]        color_mode,
  input logic [GAIN_W-1:0] fine_gain,
  input logic [1:0]        tia_code,
  input logic              tail_en,
  input logic [2:0]        tail_time,
  input logic [2:0]        tail_mag
);
  AST_SLEEP_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (fine_gain == '0 && tia_code == 2'd0 && !tail_en)); // R7

  AST_TAIL_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !tail_en |-> (tail_time == 3'd0 && tail_mag == 3'd0)); // R6

  AST_PIN_LOW_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_pin |-> !bank_high); // R3

  AST_BLUE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'('h10) && reg_wdata[5]) |=> (color_mode == 2'd2)); // R4

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(bank_pin) -> $stable(fine_gain))); // R10

  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'('h00)) |-> (reg_rdata == DATA_W'('h28))); // R8

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'('h1D)) |-> (reg_rdata == '0)); // R9
endmodule

bind gain_bank_select gain_bank_select_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bank_pin(bank_pin),
  .sleep(sleep), .bank_high(bank_high), .color_mode(color_mode),
  .fine_gain(fine_gain), .tia_code(tia_code), .tail_en(tail_en),
  .tail_time(tail_time), .tail_mag(tail_mag)
);

// File: tb/gain_bank_select_test.sv
`timescale 1ns/1ps
module gain_bank_select_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic bank_pin = 1'b0;
  logic sleep, bank_high, tail_en;
  logic [1:0] color_mode, tia_code;
  logic [11:0] fine_gain;
  logic [2:0] tail_time, tail_mag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gain_bank_select uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bank_pin(bank_pin),
    .sleep(sleep), .bank_high(bank_high), .color_mode(color_mode),
    .fine_gain(fine_gain), .tia_code(tia_code), .tail_en(tail_en),
    .tail_time(tail_time), .tail_mag(tail_mag)
  );

  // behavioural model: a byte image of the register space
  byte unsigned img [128];

  task automatic model_reset();
    for (int a = 0; a < 128; a++) img[a] = 0;
    img['h00] = 8'h28; img['h01] = 8'hE0; img['h03] = 8'h43;
    for (int a = 'h11; a <= 'h19; a++) img[a] = ((a - 'h11) % 3 == 0) ? 8'hFF : 8'h7F;
  endtask

  task automatic model_write(input int a, input byte unsigned d);
    if (a == 'h03 || (a >= 'h11 && a <= 'h19)) img[a] = d;
    else if (a == 'h10) img[a] = d & 8'hF9;
    else if (a == 'h1C) img[a] = d & 8'h0F;
    else if (a == 'h1A || a == 'h1B || a == 'h1E) img[a] = d[7] ? (d & 8'hF7) : 8'h00;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else if (reg_wr) model_write(int'(reg_addr), reg_wdata);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // compare everything against the model after every edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      int hb, col, base, ta, g, t, tl;
      byte unsigned c;
      c = img['h10];
      hb = (bank_pin && c[7]) ? 1 : 0;
      col = c[5] ? 2 : (c[4] ? 1 : 0);
      base = (col == 2) ? 'h11 : ((col == 1) ? 'h14 : 'h17);
      ta = (col == 2) ? 'h1E : ((col == 1) ? 'h1A : 'h1B);
      g = hb ? (img[base+1] * 16 + img[base] / 16) : (img[base+2] * 16 + img[base] % 16);
      t = hb ? (img['h1C] / 4) % 4 : img['h1C] % 4;
      tl = img[ta];
      if (!c[0]) begin g = 0; t = 0; tl = 0; end
      chk("R3 bank_high", int'(bank_high), hb);
      chk("R4 color_mode", int'(color_mode), col);
      chk("R2 fine_gain", int'(fine_gain), g);
      chk("R5 tia_code", int'(tia_code), t);
      chk("R6 tail", {tail_en, tail_time, 1'b0, tail_mag}, tl);
      chk("R7 sleep", int'(sleep), c[0] ? 0 : 1);
      chk("R10 rdata", int'(reg_rdata), int'(img[reg_addr]));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input string tag, input int a, input int exp);
    @(negedge clk);
    reg_addr = 7'(a);
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values, R8 identification bytes
    rd("R8 id0", 'h00, 'h28);
    rd("R8 id1", 'h01, 'hE0);
    rd("R8 id2", 'h02, 'h00);
    rd("R1 dsel", 'h03, 'h43);
    rd("R1 ctrl", 'h10, 'h00);
    rd("R1 nibble", 'h17, 'hFF);
    rd("R1 upper", 'h15, 'h7F);
    chk("R7 sleep at reset", int'(sleep), 1);
    chk("R7 gain zero in sleep", int'(fine_gain), 0);
    wr('h10, 'h01);
    chk("R1 gain default", int'(fine_gain), 'h7FF);
    chk("R4 green default", int'(color_mode), 0);
    // R2 nibble split, R3 bank AND
    wr('h18, 'hAB);
    wr('h17, 'hC5);
    chk("R2 green low", int'(fine_gain), 'h7F5);
    bank_pin = 1'b1;
    #1 chk("R3 pin alone", int'(bank_high), 0);
    wr('h10, 'h81);
    chk("R2 green high", int'(fine_gain), 'hABC);
    @(negedge clk); bank_pin = 1'b0; #1;
    chk("R3 pin low", int'(fine_gain), 'h7F5);
    // R4 blue overrides red
    bank_pin = 1'b1;
    wr('h10, 'hB1);
    chk("R4 blue wins", int'(color_mode), 2);
    wr('h12, 'h12);
    wr('h11, 'h3F);
    chk("R10 immediate", int'(fine_gain), 'h123);
    wr('h10, 'h91);
    chk("R4 red", int'(color_mode), 1);
    chk("R2 red default", int'(fine_gain), 'h7FF);
    // R5
    wr('h1C, 'hF6);
    rd("R5 readback", 'h1C, 'h06);
    chk("R5 high code", int'(tia_code), 1);
    @(negedge clk); bank_pin = 1'b0; #1;
    chk("R5 low code", int'(tia_code), 2);
    // R6
    wr('h1A, 'h7F);
    rd("R6 disabled clear", 'h1A, 'h00);
    wr('h1A, 'hFF);
    rd("R6 bit3 zero", 'h1A, 'hF7);
    chk("R6 tail out", {tail_en, tail_time, tail_mag}, 'h7F);
    wr('h1A, 'h35);
    chk("R6 tail cleared", {tail_en, tail_time, tail_mag}, 0);
    // R7
    wr('h1A, 'hA3);
    wr('h10, 'h90);
    chk("R7 sleep flag", int'(sleep), 1);
    chk("R7 tail zero", {tail_en, tail_time, tail_mag}, 0);
    // R8, R9, R10
    wr('h00, 'h55);
    rd("R8 id0 write ignored", 'h00, 'h28);
    wr('h03, 'h9A);
    rd("R8 dsel write", 'h03, 'h9A);
    wr('h1D, 'hFF);
    rd("R9 hole 1D", 'h1D, 'h00);
    wr('h7F, 'hFF);
    rd("R9 hole 7F", 'h7F, 'h00);
    wr('h10, 'h4E);
    rd("R10 ctrl bits", 'h10, 'h48);
    // random phase: writes and pin changes on the same edges
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      reg_wr = ($urandom_range(0, 9) < 6);
      case ($urandom_range(0, 5))
        0: reg_addr = 7'h10;
        1, 2: reg_addr = 7'($urandom_range('h11, 'h19));
        3: reg_addr = 7'($urandom_range('h1A, 'h1F));
        4: reg_addr = 7'($urandom_range(0, 127));
        default: reg_addr = 7'($urandom_range(0, 'h10));
      endcase
      reg_wdata = 8'($urandom_range(0, 255));
      if (reg_addr == 7'h10 && $urandom_range(0, 3) != 0) reg_wdata[0] = 1'b1;
      if ($urandom_range(0, 2) == 0) bank_pin = ~bank_pin;
    end
    @(negedge clk); reg_wr = 1'b0;
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule